// File: doc/BRIEF.md
# Bus Address Latch and Decoder

This block sits on an expansion-bus slave card and holds the address of each bus cycle. Everything is sampled on the single system clock, and the strobe edges are found in logic. The 20 lower address lines are taken in on the clock where the address-latch strobe is first seen low after being high, and they are then held for the rest of the cycle. The 7 unlatched upper lines (address bits 23 down to 17) are only trustworthy while the strobe is high. So they are sampled, and decoded, on every clock with the strobe high. The held 24-bit address is made from address bits 23..20 out of the upper group and bits 19..0 out of the lower group.

Two decodes are registered. The first flags an address below 1 MB. The second flags a hit in a window whose base and power-of-two size are parameters. The first-megabyte flag gates the general active-low memory read and write strobes into first-megabyte-only strobes. When the DMA address-enable input is high, the block reloads the whole address and both decodes on every clock and raises a DMA-ownership flag.

Top module: `bus_addr_capture`

## Requirements
- R1: A synchronous active-high reset sets the held address to 0, clears the window-hit, first-megabyte and DMA flags, and drives both qualified strobes high (inactive).
- R2: Outside DMA, the held address bits 19..0 load from the lower lines only on the clock where the strobe is sampled low and was high at the previous clock. Lower-line changes at any other clock have no effect.
- R3: Outside DMA, held address bits 23..20 come from bits 6..3 of the upper-line input (upper-line input bit 0 is address bit 17). They are reloaded on every clock at which the strobe is sampled high. Upper-line changes while the strobe is low have no effect.
- R4: The first-megabyte flag is set when address bits 23..20 on the upper lines are all zero at a strobe-high sample. It is cleared when they are not, and it holds its value while the strobe is low.
- R5: The window-hit flag is loaded together with the lower bits. It is 1 when the 24-bit address formed at that moment lies in [WIN_BASE, WIN_BASE + 2^WIN_LOG2). The default window is 0x0C8000 to 0x0CBFFF.
- R6: The qualified read strobe is low one clock after a sample with the general read strobe low and the first-megabyte decode set. It is high otherwise.
- R7: The qualified write strobe follows the rule of R6, using the general write strobe.
- R8: While address-enable is high, every clock loads all 24 held address bits, the first-megabyte flag and the window-hit flag from the lines, whatever the strobe does. The DMA flag equals the address-enable input one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| lo_addr_i | input | 20 | Lower address lines, bits 19..0 |
| hi_addr_i | input | 7 | Unlatched upper address lines, bits 23..17 |
| ale_i | input | 1 | Address-latch strobe, active high |
| dma_en_i | input | 1 | DMA address enable, active high |
| memrd_n_i | input | 1 | General memory read strobe, active low |
| memwr_n_i | input | 1 | General memory write strobe, active low |
| addr_o | output | 24 | Held address |
| win_hit_o | output | 1 | Registered window decode |
| low_mb_o | output | 1 | Registered first-megabyte decode |
| lowrd_n_o | output | 1 | First-megabyte read strobe, active low |
| lowwr_n_o | output | 1 | First-megabyte write strobe, active low |
| dma_own_o | output | 1 | Cycle owned by DMA |

## Verification
Every result is registered once, so each one is due exactly one rising edge after the sample that causes it. The upper address bits and the first-megabyte flag follow the strobe-high edge. The lower bits and the window hit follow the first strobe-low edge. The qualified strobes and the DMA flag follow the edge that sampled their inputs. The bench changes inputs only on falling edges and reads the outputs at the next falling edge, after the one rising edge that should have updated them. To prove that inputs are ignored, it scrambles lines outside their capture phase and then reads the held values back through the outputs.

// File: rtl/bac_pkg.sv
package bac_pkg;
    localparam int BAC_STB_N = 2;

    typedef enum logic [0:0] {
        STB_RD = 1'b0,
        STB_WR = 1'b1
    } bac_stb_e;

    typedef struct packed {
        logic low_mb;
        logic hit;
        logic dma;
    } bac_flags_t;
endpackage

// File: rtl/bac_win_dec.sv
module bac_win_dec #(
    parameter int             AW       = 24,
    parameter logic [AW-1:0]  BASE     = '0,
    parameter int             SIZE_LOG2 = 20
) (
    input  logic [AW-1:0] addr_i,
    output logic          hit_o
);
    localparam logic [AW:0]   SPAN = (SIZE_LOG2 >= AW) ? {1'b1, {AW{1'b0}}} : ((AW+1)'(1) << SIZE_LOG2);
    localparam logic [AW-1:0] MASK = ~(SPAN[AW-1:0] - AW'(1)) & ((SIZE_LOG2 >= AW) ? '0 : '1);

    // Aligned window: compare only the bits above the window size.
    assign hit_o = ((addr_i ^ BASE) & MASK) == '0;
endmodule

// File: rtl/bac_strobe_gate.sv
module bac_strobe_gate #(
    parameter int N = 2
) (
    input  logic [N-1:0] strb_n_i,
    input  logic         en_i,
    output logic [N-1:0] strb_n_o
);
    for (genvar g = 0; g < N; g++) begin : g_gate
        assign strb_n_o[g] = strb_n_i[g] | ~en_i;
    end
endmodule

// File: rtl/bus_addr_capture.sv
module bus_addr_capture
    import bac_pkg::*;
#(
    parameter int            AW       = 24,
    parameter int            LO_W     = 20,
    parameter int            HI_LSB   = 17,
    parameter logic [AW-1:0] WIN_BASE = 24'h0C8000,
    parameter int            WIN_LOG2 = 14
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [LO_W-1:0]      lo_addr_i,
    input  logic [AW-HI_LSB-1:0] hi_addr_i,
    input  logic                 ale_i,
    input  logic                 dma_en_i,
    input  logic                 memrd_n_i,
    input  logic                 memwr_n_i,
    output logic [AW-1:0]        addr_o,
    output logic                 win_hit_o,
    output logic                 low_mb_o,
    output logic                 lowrd_n_o,
    output logic                 lowwr_n_o,
    output logic                 dma_own_o
);
    localparam int HI_W = AW - HI_LSB;
    localparam int UP_W = AW - LO_W;

    typedef struct packed {
        logic [UP_W-1:0]      up;
        logic [LO_W-1:0]      lo;
        logic                 ale;
        bac_flags_t           flags;
        logic [BAC_STB_N-1:0] stb_n;
    } st_t;

    st_t st_d, st_q;

    logic                 fall_w, load_up_w, load_lo_w;
    logic                 low_hit_w, win_hit_w, low_mb_d;
    logic [UP_W-1:0]      cand_up_w;
    logic [BAC_STB_N-1:0] stb_raw_n_w, stb_gated_n_w;

    assign fall_w    = st_q.ale & ~ale_i;
    assign load_up_w = ale_i | dma_en_i;
    assign load_lo_w = fall_w | dma_en_i;
    assign cand_up_w = dma_en_i ? hi_addr_i[HI_W-1 -: UP_W] : st_q.up;
    assign low_mb_d  = load_up_w ? low_hit_w : st_q.flags.low_mb;

    assign stb_raw_n_w[STB_RD] = memrd_n_i;
    assign stb_raw_n_w[STB_WR] = memwr_n_i;

    bac_win_dec #(
        .AW        (AW),
        .BASE      ('0),
        .SIZE_LOG2 (LO_W)
    ) u_low_dec (
        .addr_i ({hi_addr_i, {HI_LSB{1'b0}}}),
        .hit_o  (low_hit_w)
    );

    bac_win_dec #(
        .AW        (AW),
        .BASE      (WIN_BASE),
        .SIZE_LOG2 (WIN_LOG2)
    ) u_win_dec (
        .addr_i ({cand_up_w, lo_addr_i}),
        .hit_o  (win_hit_w)
    );

    bac_strobe_gate #(
        .N (BAC_STB_N)
    ) u_gate (
        .strb_n_i (stb_raw_n_w),
        .en_i     (low_mb_d),
        .strb_n_o (stb_gated_n_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.ale = ale_i;
        if (load_up_w) begin
            st_d.up           = hi_addr_i[HI_W-1 -: UP_W];
            st_d.flags.low_mb = low_hit_w;
        end
        if (load_lo_w) begin
            st_d.lo        = lo_addr_i;
            st_d.flags.hit = win_hit_w;
        end
        st_d.flags.dma = dma_en_i;
        st_d.stb_n     = stb_gated_n_w;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q       <= '0;
            st_q.stb_n <= '1;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o    = {st_q.up, st_q.lo};
    assign win_hit_o = st_q.flags.hit;
    assign low_mb_o  = st_q.flags.low_mb;
    assign dma_own_o = st_q.flags.dma;
    assign lowrd_n_o = st_q.stb_n[STB_RD];
    assign lowwr_n_o = st_q.stb_n[STB_WR];

    // R2
    lo_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!(st_q.ale && !ale_i) && !dma_en_i) |=> $stable(addr_o[LO_W-1:0]));

    // R3
    up_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (!ale_i && !dma_en_i) |=> ($stable(addr_o[AW-1:LO_W]) && $stable(low_mb_o)));

    // R4
    low_mb_set_chk: assert property (@(posedge clk) disable iff (rst)
        (ale_i && hi_addr_i[HI_W-1 -: UP_W] == '0) |=> low_mb_o);

    // R4
    low_mb_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (ale_i && hi_addr_i[HI_W-1 -: UP_W] != '0) |=> !low_mb_o);

    // R6
    rd_idle_chk: assert property (@(posedge clk) disable iff (rst)
        memrd_n_i |=> lowrd_n_o);

    // R7
    wr_idle_chk: assert property (@(posedge clk) disable iff (rst)
        memwr_n_i |=> lowwr_n_o);

    // R8
    dma_flag_chk: assert property (@(posedge clk) disable iff (rst)
        dma_en_i |=> dma_own_o);
endmodule

// File: tb/bus_addr_capture_bench.sv
module bus_addr_capture_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic [19:0] lo_addr;
    logic [6:0]  hi_addr;
    logic        ale, dma_en, rd_n, wr_n;
    logic [23:0] addr;
    logic        hit, low_mb, lrd_n, lwr_n, dma_own;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    bus_addr_capture u_bus_addr_capture (
        .clk       (clk),
        .rst       (rst),
        .lo_addr_i (lo_addr),
        .hi_addr_i (hi_addr),
        .ale_i     (ale),
        .dma_en_i  (dma_en),
        .memrd_n_i (rd_n),
        .memwr_n_i (wr_n),
        .addr_o    (addr),
        .win_hit_o (hit),
        .low_mb_o  (low_mb),
        .lowrd_n_o (lrd_n),
        .lowwr_n_o (lwr_n),
        .dma_own_o (dma_own)
    );

    // {addr[23:0], rd_n, wr_n, exp_hit, exp_low_mb, exp_lrd_n, exp_lwr_n}
    localparam logic [29:0] VEC [8] = '{
        {24'h0C8000, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1},
        {24'h0CBFFF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0},
        {24'h0CC000, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1},
        {24'h0C7FFF, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0},
        {24'h100000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1},
        {24'hFFFFFF, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1},
        {24'h0FFFFF, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0},
        {24'h8C8000, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic put_addr(input logic [23:0] a);
        hi_addr = a[23:17];
        lo_addr = a[19:0];
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hang expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; ale = 1'b0; dma_en = 1'b0; rd_n = 1'b1; wr_n = 1'b1;
        put_addr(24'hA5A5A5);
        @(negedge clk);
        tick(); tick();
        // R1 reset state
        chk("R1 addr", 32'(addr), 32'h0);
        chk("R1 hit", 32'(hit), 0);
        chk("R1 low_mb", 32'(low_mb), 0);
        chk("R1 dma", 32'(dma_own), 0);
        chk("R1 lrd_n", 32'(lrd_n), 1);
        chk("R1 lwr_n", 32'(lwr_n), 1);
        rst = 1'b0;
        tick();

        for (int i = 0; i < 8; i++) begin
            logic [23:0] a;
            a = VEC[i][29:6];
            ale = 1'b1; put_addr(a);
            tick();
            // strobe low: scramble upper lines (R3 ignored)
            ale = 1'b0; hi_addr = ~a[23:17];
            tick();
            // lower held: scramble them (R2 ignored), assert strobes
            lo_addr = ~a[19:0]; rd_n = VEC[i][5]; wr_n = VEC[i][4];
            tick();
            chk("R2/R3 addr", 32'(addr), 32'(a));
            chk("R5 hit", 32'(hit), 32'(VEC[i][3]));
            chk("R4 low_mb", 32'(low_mb), 32'(VEC[i][2]));
            chk("R6 lrd_n", 32'(lrd_n), 32'(VEC[i][1]));
            chk("R7 lwr_n", 32'(lwr_n), 32'(VEC[i][0]));
            rd_n = 1'b1; wr_n = 1'b1;
            tick();
            chk("R6 idle", 32'(lrd_n), 1);
        end

        // R2: lower lines ignored while strobe stays low
        lo_addr = 20'h12345;
        tick(); tick();
        chk("R2 hold", 32'(addr), 32'h8C8000);

        // R3 upper reloads on strobe high; R2 lower not yet taken
        ale = 1'b1; put_addr(24'h2ABCDE);
        tick();
        chk("R3 upper early", 32'(addr), 32'h2C8000);
        chk("R2 lower waits", 32'(addr[19:0]), 32'hC8000);
        ale = 1'b0;
        tick();
        chk("R2 fall load", 32'(addr), 32'h2ABCDE);
        chk("R5 miss", 32'(hit), 0);
        chk("R4 high addr", 32'(low_mb), 0);

        // R8 DMA: continuous loading with strobe held high
        dma_en = 1'b1; ale = 1'b1; put_addr(24'h012345); rd_n = 1'b0;
        tick();
        chk("R8 addr", 32'(addr), 32'h012345);
        chk("R8 dma_own", 32'(dma_own), 1);
        chk("R8 low_mb", 32'(low_mb), 1);
        chk("R6 dma rd", 32'(lrd_n), 0);
        put_addr(24'h0C9000);
        tick();
        chk("R8 follow", 32'(addr), 32'h0C9000);
        chk("R8 hit", 32'(hit), 1);
        dma_en = 1'b0; ale = 1'b0; rd_n = 1'b1;
        tick();
        chk("R8 dma clear", 32'(dma_own), 0);
        chk("R8 addr kept", 32'(addr), 32'h0C9000);

        // R1 reset in mid operation
        rd_n = 1'b0; rst = 1'b1;
        tick();
        chk("R1 re-reset addr", 32'(addr), 0);
        chk("R1 re-reset hit", 32'(hit), 0);
        chk("R1 re-reset lrd_n", 32'(lrd_n), 1);
        rst = 1'b0; rd_n = 1'b1;
        tick();

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end
endmodule